// File: doc/BRIEF.md
# Cascadable Parity Generator and Checker

This block decides whether a data word holds an even or an odd number of ones and reports the answer on a pair of complementary flags. Two steering inputs set how the answer is reported. With one setting the flags show the parity as it is. With the opposite setting they are swapped. Driving both steering inputs to the same level forces both flags to a fixed value, whatever the data. The same slice therefore serves as an even-parity checker, as an odd-parity checker, or as the source of a parity bit that is appended to a word.

Each slice examines eight bits. The slices are chained: the flag pair of one slice becomes the steering pair of the next, so the parameterised chain reports the parity of the whole word. The default build has two slices and covers 16 bits. The flag pair of every slice is also brought out, so that the lowest slice can be used on its own. The block has no clock and no state. Every output follows its inputs within the same cycle.

Top module: `par_chain`

## Requirements
- R1: With the steering pair {even_in_i, odd_in_i} = 2'b10, a slice whose eight bits hold an even number of ones drives {even, odd} = 2'b10, and one whose bits hold an odd number drives 2'b01.
- R2: With the steering pair 2'b01, the slice result is swapped. An even count of ones gives {even, odd} = 2'b01 and an odd count gives 2'b10.
- R3: With the steering pair 2'b11, the slice drives {even, odd} = 2'b00 for any data.
- R4: With the steering pair 2'b00, the slice drives {even, odd} = 2'b11 for any data.
- R5: Whenever the steering pair of a slice is 2'b10 or 2'b01, exactly one of that slice's two flags is high.
- R6: With the steering pair 2'b01, the odd flag of the lowest slice (tap_odd_o[0]) is a parity bit. Together with data_i[7:0] it forms a 9-bit word with an odd number of ones.
- R7: With the chain steering pair 2'b10, sum_even_o is 1 exactly when all of data_i holds an even number of ones, and sum_odd_o is its complement.
- R8: With the chain steering pair 2'b01, the final flags are swapped relative to R7.
- R9: A forced pattern flips at every slice. With the default two slices, a chain steering pair of 2'b11 gives final flags 2'b11, and 2'b00 gives 2'b00, for any data.
- R10: Slice k examines only data_i[8k+7:8k]. It is steered by slice k-1, and slice 0 is steered by the chain inputs. Changing the upper byte leaves tap_even_o[0] and tap_odd_o[0] unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 16 | Word under test. Slice k examines bits 8k+7..8k |
| even_in_i | input | 1 | Steering input to slice 0, even side |
| odd_in_i | input | 1 | Steering input to slice 0, odd side |
| sum_even_o | output | 1 | Even flag of the last slice |
| sum_odd_o | output | 1 | Odd flag of the last slice |
| tap_even_o | output | 2 | Even flag of each slice, bit k for slice k |
| tap_odd_o | output | 2 | Odd flag of each slice, bit k for slice k |

## Verification
No register lies on any path, so every flag is due zero cycles after its stimulus, in the same cycle the stimulus is applied. The bench changes the data and steering inputs just after a rising clock edge and reads every flag at the following falling edge. All inputs have settled by then, and no edge ordering can affect the value read. The expected flags come from popcounts of the stimulus, applied through the steering table. The bench applies the table one slice at a time for chained results, and for R7 it also works directly from the count over the whole word.

// File: rtl/par_pkg.sv
package par_pkg;

    // Steering / result pair carried between slices: {even side, odd side}
    typedef struct packed {
        logic even_h;
        logic odd_h;
    } sense_t;

    // Named steering settings, encoded as {even side, odd side}
    typedef enum logic [1:0] {
        STEER_FORCE_HI = 2'b00,
        STEER_SWAP     = 2'b01,
        STEER_PASS     = 2'b10,
        STEER_FORCE_LO = 2'b11
    } steer_e;

    // Combine the steering pair with the slice's odd-count flag
    function automatic sense_t apply_steer(sense_t ctl, logic odd_cnt);
        sense_t r;
        unique case (steer_e'({ctl.even_h, ctl.odd_h}))
            STEER_PASS:     r = odd_cnt ? 2'b01 : 2'b10;
            STEER_SWAP:     r = odd_cnt ? 2'b10 : 2'b01;
            STEER_FORCE_LO: r = 2'b00;
            default:        r = 2'b11;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/par_xor_tree.sv
module par_xor_tree #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits_i,
    output logic         odd_o
);
    // Pad to a power of two so that every level halves cleanly
    localparam int P = (W <= 1) ? 2 : (1 << $clog2(W));

    always_comb begin
        logic [P-1:0] acc;
        acc = '0;
        acc[W-1:0] = bits_i;
        for (int s = P / 2; s >= 1; s = s / 2) begin
            for (int k = 0; k < s; k++) begin
                acc[k] = acc[k] ^ acc[k + s];
            end
        end
        odd_o = acc[0];
    end
endmodule

// File: rtl/par_stage.sv
module par_stage
    import par_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] bits_i,
    input  sense_t       ctl_i,
    output sense_t       res_o
);
    logic odd_cnt;

    par_xor_tree #(.W(W)) u_tree (
        .bits_i (bits_i),
        .odd_o  (odd_cnt)
    );

    assign res_o = apply_steer(ctl_i, odd_cnt);
endmodule

// File: rtl/par_chain.sv
module par_chain
    import par_pkg::*;
#(
    parameter int STAGE_W = 8,
    parameter int STAGES  = 2,
    localparam int DATA_W = STAGE_W * STAGES
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              even_in_i,
    input  logic              odd_in_i,
    output logic              sum_even_o,
    output logic              sum_odd_o,
    output logic [STAGES-1:0] tap_even_o,
    output logic [STAGES-1:0] tap_odd_o
);
    // link[k] steers slice k; link[k+1] is its result
    sense_t link [STAGES+1];

    assign link[0] = '{even_h: even_in_i, odd_h: odd_in_i};

    for (genvar k = 0; k < STAGES; k++) begin : g_slice
        par_stage #(.W(STAGE_W)) u_stage (
            .bits_i (data_i[k*STAGE_W +: STAGE_W]),
            .ctl_i  (link[k]),
            .res_o  (link[k+1])
        );
        assign tap_even_o[k] = link[k+1].even_h;
        assign tap_odd_o[k]  = link[k+1].odd_h;
    end

    assign sum_even_o = link[STAGES].even_h;
    assign sum_odd_o  = link[STAGES].odd_h;
endmodule

module par_chain_chk #(
    parameter int STAGE_W = 8,
    parameter int STAGES  = 2,
    localparam int DATA_W = STAGE_W * STAGES
) (
    input logic [DATA_W-1:0] data_i,
    input logic              even_in_i,
    input logic              odd_in_i,
    input logic              sum_even_o,
    input logic              sum_odd_o,
    input logic [STAGES-1:0] tap_even_o,
    input logic [STAGES-1:0] tap_odd_o
);
    always_comb begin
        if (!$isunknown({data_i, even_in_i, odd_in_i})) begin
            if (even_in_i && odd_in_i)
                p_forced_low_r3: assert ({tap_even_o[0], tap_odd_o[0]} == 2'b00)
                    else $error("slice 0 not forced low");
            if (!even_in_i && !odd_in_i)
                p_forced_high_r4: assert ({tap_even_o[0], tap_odd_o[0]} == 2'b11)
                    else $error("slice 0 not forced high");
            if (even_in_i != odd_in_i)
                p_one_flag_r5: assert ($countones({tap_even_o[0], tap_odd_o[0]}) == 1)
                    else $error("slice 0 flags not exclusive");
            if (!even_in_i && odd_in_i)
                p_gen_odd_r6: assert (($countones(data_i[STAGE_W-1:0]) + 32'(tap_odd_o[0])) % 2 == 1)
                    else $error("generated bit does not make odd parity");
            if (even_in_i && !odd_in_i)
                p_chain_even_r7: assert (sum_even_o == ($countones(data_i) % 2 == 0) && sum_odd_o == !sum_even_o)
                    else $error("chained parity mismatch");
        end
    end
endmodule

bind par_chain par_chain_chk #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u_chk (
    .data_i     (data_i),
    .even_in_i  (even_in_i),
    .odd_in_i   (odd_in_i),
    .sum_even_o (sum_even_o),
    .sum_odd_o  (sum_odd_o),
    .tap_even_o (tap_even_o),
    .tap_odd_o  (tap_odd_o)
);

// File: tb/par_chain_tb.sv
module par_chain_tb;
    localparam int STAGE_W = 8;
    localparam int STAGES  = 2;
    localparam int DATA_W  = STAGE_W * STAGES;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic [DATA_W-1:0] data;
    logic              ev_in, od_in;
    logic              sum_even, sum_odd;
    logic [STAGES-1:0] tap_even, tap_odd;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    par_chain u_dut (
        .data_i     (data),
        .even_in_i  (ev_in),
        .odd_in_i   (od_in),
        .sum_even_o (sum_even),
        .sum_odd_o  (sum_odd),
        .tap_even_o (tap_even),
        .tap_odd_o  (tap_odd)
    );

    // Steering table from R1..R4, {even, odd}
    function automatic logic [1:0] ref_pair(logic [1:0] ctl, int ones);
        case (ctl)
            2'b10:   return (ones % 2) ? 2'b01 : 2'b10;
            2'b01:   return (ones % 2) ? 2'b10 : 2'b01;
            2'b11:   return 2'b00;
            default: return 2'b11;
        endcase
    endfunction

    // Per-slice chaining from R10
    function automatic logic [1:0] ref_chain(logic [DATA_W-1:0] d, logic [1:0] ctl);
        logic [1:0] s = ctl;
        for (int k = 0; k < STAGES; k++)
            s = ref_pair(s, $countones(d[k*STAGE_W +: STAGE_W]));
        return s;
    endfunction

    task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: data=%h ctl=%b%b actual=%b expected=%b",
                     req, data, ev_in, od_in, act, exp);
        end
    endtask

    task automatic drive(logic [DATA_W-1:0] d, logic e, logic o);
        @(posedge clk);
        data  <= d;
        ev_in <= e;
        od_in <= o;
        @(negedge clk);
    endtask

    task automatic t_idle;
        drive('0, 1'b1, 1'b0);
        chk("R1 idle tap0", {tap_even[0], tap_odd[0]}, 2'b10);
        chk("R7 idle final", {sum_even, sum_odd}, 2'b10);
    endtask

    task automatic t_single_byte;
        for (int v = 0; v < 256; v++) begin
            drive(DATA_W'(v), 1'b1, 1'b0);
            chk("R1", {tap_even[0], tap_odd[0]}, ref_pair(2'b10, $countones(v[7:0])));
            chk("R5 pass", 2'($countones({tap_even[0], tap_odd[0]})), 2'd1);
            drive(DATA_W'(v), 1'b0, 1'b1);
            chk("R2", {tap_even[0], tap_odd[0]}, ref_pair(2'b01, $countones(v[7:0])));
            chk("R5 swap", 2'($countones({tap_even[0], tap_odd[0]})), 2'd1);
        end
    endtask

    task automatic t_forced;
        logic [DATA_W-1:0] pats [4] = '{16'h0000, 16'hFFFF, 16'h0001, 16'hA5C3};
        for (int i = 0; i < 4; i++) begin
            drive(pats[i], 1'b1, 1'b1);
            chk("R3", {tap_even[0], tap_odd[0]}, 2'b00);
            chk("R9 from 11", {sum_even, sum_odd}, 2'b11);
            drive(pats[i], 1'b0, 1'b0);
            chk("R4", {tap_even[0], tap_odd[0]}, 2'b11);
            chk("R9 from 00", {sum_even, sum_odd}, 2'b00);
        end
    endtask

    task automatic t_gen_odd;
        for (int i = 0; i < 64; i++) begin
            logic [DATA_W-1:0] d = DATA_W'($urandom);
            drive(d, 1'b0, 1'b1);
            chk("R6", 2'(($countones(d[7:0]) + 32'(tap_odd[0])) % 2), 2'd1);
        end
    endtask

    task automatic t_chain;
        for (int i = 0; i < 300; i++) begin
            logic [DATA_W-1:0] d = DATA_W'($urandom);
            drive(d, 1'b1, 1'b0);
            chk("R7", {sum_even, sum_odd}, ($countones(d) % 2 == 0) ? 2'b10 : 2'b01);
            chk("R10 chain", {sum_even, sum_odd}, ref_chain(d, 2'b10));
            drive(d, 1'b0, 1'b1);
            chk("R8", {sum_even, sum_odd}, ($countones(d) % 2 == 0) ? 2'b01 : 2'b10);
        end
    endtask

    task automatic t_isolation;
        for (int i = 0; i < 32; i++) begin
            logic [7:0] lo = 8'($urandom);
            logic [1:0] first;
            drive({8'h00, lo}, 1'b1, 1'b0);
            first = {tap_even[0], tap_odd[0]};
            drive({8'h01 + 8'(i), lo}, 1'b1, 1'b0);
            chk("R10 upper byte ignored", {tap_even[0], tap_odd[0]}, first);
            chk("R10 slice1", {tap_even[1], tap_odd[1]},
                ref_chain({8'h01 + 8'(i), lo}, 2'b10));
        end
    endtask

    always @(posedge clk) begin
        if (rst) cycles <= 0;
        else     cycles <= cycles + 1;
        if (!done && cycles > WD_LIMIT) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        data  = '0;
        ev_in = 1'b1;
        od_in = 1'b0;
        repeat (3) @(posedge clk);
        rst <= 1'b0;
        t_idle();
        t_single_byte();
        t_forced();
        t_gen_odd();
        t_chain();
        t_isolation();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule